// File: doc/BRIEF.md
# Compressed Affine Vector Side Cache

This block is a small sectored cache that sits beside a conventional L1 data cache. It holds warp-wide vectors of thread-private words in compact form. Each vector is a (base, stride-code) pair plus a 32-bit per-word valid mask, and each word lane of the vector maps to one thread lane of a warp. A line holds 16 such vectors. The cache is direct-mapped, so a line is chosen by its set index and matched on its tag.

A request is either a read or a write. Both carry a vector address and a lane activity mask. A write also carries a pair that an external encoder has already produced. The block answers every request exactly one cycle later.

- For a read, the response gives the lanes served, the stored pair, and a replay mask for the requested lanes the cache does not hold.
- For a write, the response reports whether the write merged into the stored vector, replaced it, evicted an older partial vector with a different pair (a conflict), or allocated a new line.
- When an eviction leaves L1 copies stale, the block issues an invalidate-with-writeback request toward the L1 in the same response cycle.

The stride code is an opaque 3-bit field; code 0 is the one the encoder reserves for stride zero. The block stores and compares this code but never interprets it.

Top module: `avc_sector_cache`

## Requirements
- R1: After a synchronous active-low reset every line is invalid, `rsp_valid` and `inval_valid` are low, and every read misses.
- R2: Each request accepted with `req_valid` high produces `rsp_valid` high in exactly the next cycle, with `rsp_write` echoing `req_write`; a cycle without a request produces no response.
- R3: A read whose line hits and whose requested lanes are all valid returns `rsp_hit`=1, `rsp_hit_mask`=`req_mask`, the stored base and stride code, and a zero replay mask.
- R4: A read whose line hits and whose mask overlaps the valid mask only partly returns `rsp_hit_mask` = mask AND valid and `rsp_replay_mask` = mask AND NOT valid.
- R5: A read whose tag mismatches, whose line is invalid, or whose mask does not overlap the valid mask returns `rsp_hit`=0 with zero hit mask, zero replay mask, zero base and zero stride code.
- R6: A write with a non-zero mask that hits with the identical (base, stride code) ORs its mask into the valid mask and leaves the pair unchanged.
- R7: A write that hits with a different pair, while valid lanes lie outside its mask, is a conflict. The response then reports `rsp_conflict`=1, `rsp_evict_mask` = old valid mask and the old pair on `rsp_base`/`rsp_slog`. It also raises `inval_valid` with `inval_all`=0, `inval_addr` = the vector address and `inval_mask` = NOT old valid mask. Afterwards the vector holds the new pair with valid mask = write mask.
- R8: A write that hits with a different pair, where every old valid lane lies inside its mask, replaces the pair and sets valid mask = write mask, without conflict or invalidate.
- R9: A write with a non-zero mask that misses allocates the line: it sets the tag, clears the valid masks of the other 15 vectors, and stores the pair with valid mask = write mask. If the line held another valid tag, it raises `inval_valid` with `inval_all`=1, `inval_mask` all ones and `inval_addr` = {old tag, set, vector 0}.
- R10: Vector address fields are: bits [3:0] vector index, the next log2(SETS) bits set index, the remaining upper bits tag.
- R11: A write with an all-zero mask changes no state, raises no conflict and no invalidate, and reports `rsp_hit` = line hit.
- R12: Reads never change state. On writes without conflict, the response's hit mask, replay mask, evict mask, base and stride code are zero, and when no invalidate is raised the invalidate address and mask are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_vaddr | input | VADDR_W (11) | Vector address {tag, set, vector index} |
| req_mask | input | LANES (32) | Lane activity mask |
| req_base | input | DATA_W (32) | Encoded base (writes) |
| req_slog | input | SLOG_W (3) | Encoded stride code (writes) |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_write | output | 1 | Echo of request kind |
| rsp_hit | output | 1 | Read: served lanes exist; write: line hit |
| rsp_hit_mask | output | LANES | Lanes served by a read |
| rsp_replay_mask | output | LANES | Requested lanes to replay on a partial read hit |
| rsp_base | output | DATA_W | Read: stored base; conflict: evicted base |
| rsp_slog | output | SLOG_W | Read: stored stride code; conflict: evicted code |
| rsp_conflict | output | 1 | Write evicted an older partial vector |
| rsp_evict_mask | output | LANES | Valid lanes of the evicted vector |
| inval_valid | output | 1 | L1 invalidate-with-writeback request |
| inval_all | output | 1 | Invalidate covers the whole old line |
| inval_addr | output | VADDR_W | Vector (or line) address to invalidate |
| inval_mask | output | LANES | Lanes to invalidate |

## Verification
The bench builds the block with its defaults: 11-bit vector addresses, 4 sets and a 5-bit tag. That is small enough to sweep every set and vector slot from reset, then drive thousands of mixed requests into a few vector slots under three competing tags. Drawing masks from halves, single lanes, all-ones, zero and random values, and pairs from two choices, reaches merges, conflicts, clean replacements, partial hits and line replacements many times. A bench-side model computes each expected response from the requirements.

// File: rtl/avc_pkg.sv
`timescale 1ns/1ps
// Shared types for the compressed affine vector side cache.
package avc_pkg;
    // Outcome chosen for one request against the stored state.
    typedef enum logic [2:0] {
        ACT_NONE,
        ACT_MERGE,
        ACT_REPLACE,
        ACT_CONFLICT,
        ACT_ALLOC
    } avc_act_e;
endpackage

// File: rtl/avc_addr_split.sv
`timescale 1ns/1ps
// Splits a vector address into vector index, set index and tag.
// Assumes VECS and SETS are powers of two, each at least 2.
module avc_addr_split #(
    parameter int VADDR_W = 11,
    parameter int VECS    = 16,
    parameter int SETS    = 4,
    localparam int VEC_W  = $clog2(VECS),
    localparam int SET_W  = $clog2(SETS),
    localparam int TAG_W  = VADDR_W - VEC_W - SET_W
) (
    input  logic [VADDR_W-1:0] vaddr,
    output logic [VEC_W-1:0]   vec_idx,
    output logic [SET_W-1:0]   set_idx,
    output logic [TAG_W-1:0]   tag
);
    // Field slicing: vector index lowest, then set, then tag.
    always_comb begin
        vec_idx = vaddr[VEC_W-1:0];
        set_idx = vaddr[VEC_W +: SET_W];
        tag     = vaddr[VADDR_W-1 -: TAG_W];
    end
endmodule

// File: rtl/avc_tag_store.sv
`timescale 1ns/1ps
// Direct-mapped tag array with one line-valid bit per set.
// Combinational read port; one allocation write per cycle.
module avc_tag_store #(
    parameter int SETS   = 4,
    parameter int TAG_W  = 5,
    localparam int SET_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SET_W-1:0] rd_set,
    output logic [TAG_W-1:0] rd_tag,
    output logic             rd_lvalid,
    input  logic             wr_en,
    input  logic [SET_W-1:0] wr_set,
    input  logic [TAG_W-1:0] wr_tag
);
    logic [TAG_W-1:0] tag_q    [SETS];
    logic [SETS-1:0]  lvalid_q;

    // Lookup of the addressed set.
    always_comb begin
        rd_tag    = tag_q[rd_set];
        rd_lvalid = lvalid_q[rd_set];
    end

    // Line-valid bits: cleared by reset, set on allocation.
    always_ff @(posedge clk) begin
        if (!rst_n) lvalid_q <= '0;
        else if (wr_en) lvalid_q[wr_set] <= 1'b1;
    end

    // Tag storage: written on allocation only.
    always_ff @(posedge clk) begin
        if (wr_en) tag_q[wr_set] <= wr_tag;
    end

    // R9: an allocated line is valid with the written tag next cycle.
    a_r9_alloc_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (lvalid_q[$past(wr_set)] && tag_q[$past(wr_set)] == $past(wr_tag)));
endmodule

// File: rtl/avc_vec_store.sv
`timescale 1ns/1ps
// Per-vector compact storage: base, stride code and per-lane valid mask.
// Valid masks live here, beside the data, not in the tag array.
// One write per cycle; an allocating write also clears the set's other masks.
module avc_vec_store #(
    parameter int SETS   = 4,
    parameter int VECS   = 16,
    parameter int LANES  = 32,
    parameter int DATA_W = 32,
    parameter int SLOG_W = 3,
    localparam int SET_W = $clog2(SETS),
    localparam int VEC_W = $clog2(VECS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SET_W-1:0]  rd_set,
    input  logic [VEC_W-1:0]  rd_vec,
    output logic [DATA_W-1:0] rd_base,
    output logic [SLOG_W-1:0] rd_slog,
    output logic [LANES-1:0]  rd_mask,
    input  logic              wr_en,
    input  logic              wr_clear,
    input  logic [SET_W-1:0]  wr_set,
    input  logic [VEC_W-1:0]  wr_vec,
    input  logic [DATA_W-1:0] wr_base,
    input  logic [SLOG_W-1:0] wr_slog,
    input  logic [LANES-1:0]  wr_mask
);
    logic [DATA_W-1:0] base_q [SETS][VECS];
    logic [SLOG_W-1:0] slog_q [SETS][VECS];
    logic [LANES-1:0]  vmask_q[SETS][VECS];

    // Lookup of the addressed vector.
    always_comb begin
        rd_base = base_q[rd_set][rd_vec];
        rd_slog = slog_q[rd_set][rd_vec];
        rd_mask = vmask_q[rd_set][rd_vec];
    end

    // Valid masks: reset clear, write sets, allocation clears siblings.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++)
                for (int v = 0; v < VECS; v++)
                    vmask_q[s][v] <= '0;
        end else if (wr_en) begin
            for (int v = 0; v < VECS; v++) begin
                if (v == int'(wr_vec)) vmask_q[wr_set][v] <= wr_mask;
                else if (wr_clear)     vmask_q[wr_set][v] <= '0;
            end
        end
    end

    // Compact pair storage.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            base_q[wr_set][wr_vec] <= wr_base;
            slog_q[wr_set][wr_vec] <= wr_slog;
        end
    end

    // R6: every lane written is valid in the stored mask afterwards.
    a_r6_mask_kept: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (($past(wr_mask) & ~vmask_q[$past(wr_set)][$past(wr_vec)]) == '0));
endmodule

// File: rtl/avc_sector_cache.sv
`timescale 1ns/1ps
// Compressed affine vector side cache, direct-mapped, sectored by vector.
// Decides merge / replace / conflict / allocate per request and registers a
// response plus an L1 invalidate request one cycle after each request.
// Assumes the encoder supplies the pair for writes and that compact data of a
// replaced line is already reflected on the memory side.
module avc_sector_cache #(
    parameter int VADDR_W = 11,
    parameter int SETS    = 4,
    parameter int VECS    = 16,
    parameter int LANES   = 32,
    parameter int DATA_W  = 32,
    parameter int SLOG_W  = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [VADDR_W-1:0] req_vaddr,
    input  logic [LANES-1:0]   req_mask,
    input  logic [DATA_W-1:0]  req_base,
    input  logic [SLOG_W-1:0]  req_slog,
    output logic               rsp_valid,
    output logic               rsp_write,
    output logic               rsp_hit,
    output logic [LANES-1:0]   rsp_hit_mask,
    output logic [LANES-1:0]   rsp_replay_mask,
    output logic [DATA_W-1:0]  rsp_base,
    output logic [SLOG_W-1:0]  rsp_slog,
    output logic               rsp_conflict,
    output logic [LANES-1:0]   rsp_evict_mask,
    output logic               inval_valid,
    output logic               inval_all,
    output logic [VADDR_W-1:0] inval_addr,
    output logic [LANES-1:0]   inval_mask
);
    import avc_pkg::*;

    localparam int VEC_W = $clog2(VECS);
    localparam int SET_W = $clog2(SETS);
    localparam int TAG_W = VADDR_W - VEC_W - SET_W;

    logic [VEC_W-1:0]  vec_idx;
    logic [SET_W-1:0]  set_idx;
    logic [TAG_W-1:0]  req_tag, old_tag;
    logic              lvalid;
    logic [DATA_W-1:0] old_base;
    logic [SLOG_W-1:0] old_slog;
    logic [LANES-1:0]  old_mask;
    logic              line_hit, pair_same;
    avc_act_e          act;
    logic [LANES-1:0]  new_mask;

    avc_addr_split #(.VADDR_W(VADDR_W), .VECS(VECS), .SETS(SETS)) u_split (
        .vaddr(req_vaddr), .vec_idx(vec_idx), .set_idx(set_idx), .tag(req_tag)
    );

    avc_tag_store #(.SETS(SETS), .TAG_W(TAG_W)) u_tags (
        .clk(clk), .rst_n(rst_n),
        .rd_set(set_idx), .rd_tag(old_tag), .rd_lvalid(lvalid),
        .wr_en(act == ACT_ALLOC), .wr_set(set_idx), .wr_tag(req_tag)
    );

    avc_vec_store #(.SETS(SETS), .VECS(VECS), .LANES(LANES),
                    .DATA_W(DATA_W), .SLOG_W(SLOG_W)) u_vecs (
        .clk(clk), .rst_n(rst_n),
        .rd_set(set_idx), .rd_vec(vec_idx),
        .rd_base(old_base), .rd_slog(old_slog), .rd_mask(old_mask),
        .wr_en(act != ACT_NONE), .wr_clear(act == ACT_ALLOC),
        .wr_set(set_idx), .wr_vec(vec_idx),
        .wr_base(req_base), .wr_slog(req_slog), .wr_mask(new_mask)
    );

    // Write outcome classification against the addressed vector.
    always_comb begin
        line_hit  = lvalid && (old_tag == req_tag);
        pair_same = (old_base == req_base) && (old_slog == req_slog);
        act       = ACT_NONE;
        if (req_valid && req_write && (req_mask != '0)) begin
            if (!line_hit)                        act = ACT_ALLOC;
            else if (pair_same)                   act = ACT_MERGE;
            else if ((old_mask & ~req_mask) != '0) act = ACT_CONFLICT;
            else                                  act = ACT_REPLACE;
        end
        new_mask = (act == ACT_MERGE) ? (old_mask | req_mask) : req_mask;
    end

    logic              n_hit, n_conf, n_iv, n_iall;
    logic [LANES-1:0]  n_hmask, n_rmask, n_evict, n_imask;
    logic [DATA_W-1:0] n_base;
    logic [SLOG_W-1:0] n_slog;
    logic [VADDR_W-1:0] n_iaddr;

    // Response and invalidate contents for the current request.
    always_comb begin
        n_hit = 1'b0; n_conf = 1'b0; n_iv = 1'b0; n_iall = 1'b0;
        n_hmask = '0; n_rmask = '0; n_evict = '0; n_imask = '0;
        n_base = '0; n_slog = '0; n_iaddr = '0;
        if (!req_write) begin
            if (line_hit && ((req_mask & old_mask) != '0)) begin
                n_hit   = 1'b1;
                n_hmask = req_mask & old_mask;
                n_rmask = req_mask & ~old_mask;
                n_base  = old_base;
                n_slog  = old_slog;
            end
        end else begin
            n_hit = line_hit;
            if (act == ACT_CONFLICT) begin
                n_conf  = 1'b1;
                n_evict = old_mask;
                n_base  = old_base;
                n_slog  = old_slog;
                n_iv    = 1'b1;
                n_iaddr = req_vaddr;
                n_imask = ~old_mask;
            end else if (act == ACT_ALLOC && lvalid) begin
                n_iv    = 1'b1;
                n_iall  = 1'b1;
                n_iaddr = {old_tag, set_idx, {VEC_W{1'b0}}};
                n_imask = '1;
            end
        end
    end

    // Response register: one cycle after each request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0; rsp_write <= 1'b0; rsp_hit <= 1'b0;
            rsp_hit_mask <= '0; rsp_replay_mask <= '0;
            rsp_base <= '0; rsp_slog <= '0;
            rsp_conflict <= 1'b0; rsp_evict_mask <= '0;
            inval_valid <= 1'b0; inval_all <= 1'b0;
            inval_addr <= '0; inval_mask <= '0;
        end else begin
            rsp_valid       <= req_valid;
            rsp_write       <= req_write;
            rsp_hit         <= n_hit;
            rsp_hit_mask    <= n_hmask;
            rsp_replay_mask <= n_rmask;
            rsp_base        <= n_base;
            rsp_slog        <= n_slog;
            rsp_conflict    <= req_valid && n_conf;
            rsp_evict_mask  <= n_evict;
            inval_valid     <= req_valid && n_iv;
            inval_all       <= n_iall;
            inval_addr      <= n_iaddr;
            inval_mask      <= n_imask;
        end
    end

    // R2: a request is answered in the next cycle, and only then.
    a_r2_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (rsp_valid && rsp_write == $past(req_write)));
    a_r2_rsp_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    // R4: served and replayed lanes of a read hit cover the request mask.
    a_r4_lanes_cover: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=>
            (!rsp_hit || ((rsp_hit_mask | rsp_replay_mask) == $past(req_mask))));
    // R5: a read miss serves and replays nothing.
    a_r5_miss_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_write && !rsp_hit) |->
            (rsp_hit_mask == '0 && rsp_replay_mask == '0));
    // R7: a conflict always comes with a per-vector L1 invalidate.
    a_r7_conflict_inval: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_conflict |-> (rsp_write && inval_valid && !inval_all &&
                          inval_mask == ~rsp_evict_mask));
endmodule

// File: tb/sim_avc_sector_cache.sv
`timescale 1ns/1ps
// Self-checking bench: directed sweep over all slots plus a long mixed stream
// checked against a model built from the requirements.
module sim_avc_sector_cache;
    localparam int AW = 11;
    localparam int NS = 4;
    localparam int NV = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0] req_vaddr = '0;
    logic [31:0] req_mask = '0, req_base = '0;
    logic [2:0]  req_slog = '0;
    logic rsp_valid, rsp_write, rsp_hit, rsp_conflict, inval_valid, inval_all;
    logic [31:0] rsp_hit_mask, rsp_replay_mask, rsp_base, rsp_evict_mask, inval_mask;
    logic [2:0]  rsp_slog;
    logic [AW-1:0] inval_addr;

    avc_sector_cache u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_vaddr(req_vaddr), .req_mask(req_mask), .req_base(req_base),
        .req_slog(req_slog), .rsp_valid(rsp_valid), .rsp_write(rsp_write),
        .rsp_hit(rsp_hit), .rsp_hit_mask(rsp_hit_mask),
        .rsp_replay_mask(rsp_replay_mask), .rsp_base(rsp_base),
        .rsp_slog(rsp_slog), .rsp_conflict(rsp_conflict),
        .rsp_evict_mask(rsp_evict_mask), .inval_valid(inval_valid),
        .inval_all(inval_all), .inval_addr(inval_addr), .inval_mask(inval_mask)
    );

    always #10 clk = ~clk;  // 50 MHz

    int n_vec = 0, n_bad = 0;
    logic [4:0]  m_tag [NS];
    logic        m_lv  [NS];
    logic [31:0] m_base[NS][NV];
    logic [2:0]  m_slog[NS][NV];
    logic [31:0] m_vm  [NS][NV];
    logic [31:0] rng = 32'h1234_5678;

    task automatic chk(input string rq, input string fld,
                       input logic [63:0] act, input logic [63:0] exp);
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", rq, fld, act, exp);
        end
    endtask

    function automatic logic [31:0] nxt();
        rng ^= rng << 13; rng ^= rng >> 17; rng ^= rng << 5;
        return rng;
    endfunction

    // Apply one request, predict the response, check it one cycle later.
    task automatic apply(input logic wr, input logic [4:0] t, input int s,
                         input int v, input logic [31:0] m,
                         input logic [31:0] b, input logic [2:0] sl);
        logic e_hit = 0, e_conf = 0, e_iv = 0, e_iall = 0;
        logic [31:0] e_hm = 0, e_rm = 0, e_ev = 0, e_im = 0, e_b = 0;
        logic [2:0] e_sl = 0;
        logic [AW-1:0] e_ia = 0;
        logic lh;
        logic [31:0] old;
        string rq;
        // R10: vector address = {tag, set, vector index}.
        req_valid = 1; req_write = wr; req_mask = m; req_base = b; req_slog = sl;
        req_vaddr = {t, 2'(s), 4'(v)};
        lh = m_lv[s] && m_tag[s] == t;
        old = m_vm[s][v];
        if (!wr) begin
            if (lh && (m & old) != 0) begin
                e_hit = 1; e_hm = m & old; e_rm = m & ~old;
                e_b = m_base[s][v]; e_sl = m_slog[s][v];
                rq = (e_rm != 0) ? "R4" : "R3";
            end else rq = "R5";
        end else if (m == 0) begin
            e_hit = lh; rq = "R11";
        end else if (lh) begin
            e_hit = 1;
            if (b == m_base[s][v] && sl == m_slog[s][v]) begin
                m_vm[s][v] = old | m; rq = "R6";
            end else begin
                if ((old & ~m) != 0) begin
                    e_conf = 1; e_ev = old; e_b = m_base[s][v]; e_sl = m_slog[s][v];
                    e_iv = 1; e_ia = req_vaddr; e_im = ~old; rq = "R7";
                end else rq = "R8";
                m_vm[s][v] = m; m_base[s][v] = b; m_slog[s][v] = sl;
            end
        end else begin
            rq = "R9";
            if (m_lv[s]) begin
                e_iv = 1; e_iall = 1; e_im = '1; e_ia = {m_tag[s], 2'(s), 4'd0};
            end
            m_lv[s] = 1; m_tag[s] = t;
            for (int k = 0; k < NV; k++) m_vm[s][k] = 0;
            m_vm[s][v] = m; m_base[s][v] = b; m_slog[s][v] = sl;
        end
        @(negedge clk);
        n_vec++;
        chk("R2", "rsp_valid", 64'(rsp_valid), 64'd1);
        chk("R2", "rsp_write", 64'(rsp_write), 64'(wr));
        chk(rq, "rsp_hit", 64'(rsp_hit), 64'(e_hit));
        chk(rq, "hit_mask", 64'(rsp_hit_mask), 64'(e_hm));
        chk(rq, "replay_mask", 64'(rsp_replay_mask), 64'(e_rm));
        chk(rq, "base", 64'(rsp_base), 64'(e_b));
        chk(rq, "slog", 64'(rsp_slog), 64'(e_sl));
        chk(rq, "conflict", 64'(rsp_conflict), 64'(e_conf));
        chk(rq, "evict_mask", 64'(rsp_evict_mask), 64'(e_ev));
        chk(rq, "inval_valid", 64'(inval_valid), 64'(e_iv));
        chk(rq, "inval_all", 64'(inval_all), 64'(e_iall));
        chk(rq, "inval_addr", 64'(inval_addr), 64'(e_ia));
        chk(rq, "inval_mask", 64'(inval_mask), 64'(e_im));
    endtask

    function automatic logic [31:0] pick_mask(input int sel);
        case (sel)
            0: return 32'hFFFF_FFFF;
            1: return 32'h0000_FFFF;
            2: return 32'hFFFF_0000;
            3: return 32'h1 << (nxt() % 32);
            4: return 32'h0;
            default: return nxt();
        endcase
    endfunction

    initial begin
        for (int s = 0; s < NS; s++) begin
            m_lv[s] = 0; m_tag[s] = 0;
            for (int v = 0; v < NV; v++) begin
                m_vm[s][v] = 0; m_base[s][v] = 0; m_slog[s][v] = 0;
            end
        end
        repeat (3) @(negedge clk);
        // R1: outputs idle under reset.
        n_vec++;
        chk("R1", "rsp_valid", 64'(rsp_valid), 64'd0);
        chk("R1", "inval_valid", 64'(inval_valid), 64'd0);
        rst_n = 1;
        // R1 / R5: every slot misses after reset.
        for (int s = 0; s < NS; s++)
            for (int v = 0; v < NV; v++)
                apply(0, 5'(s), s, v, 32'hFFFF_FFFF, 0, 0);
        // R9 then R3/R4: fill every slot, read back full and partial.
        for (int s = 0; s < NS; s++)
            for (int v = 0; v < NV; v++) begin
                apply(1, 5'd1, s, v, (v % 2) ? 32'h0000_FFFF : 32'hFFFF_FFFF,
                      32'(s * 256 + v * 4), 3'(v % 8));
                apply(0, 5'd1, s, v, 32'hFFFF_FFFF, 0, 0);
            end
        // R2: an idle cycle yields no response.
        req_valid = 0;
        @(negedge clk); @(negedge clk);
        n_vec++;
        chk("R2", "rsp_valid idle", 64'(rsp_valid), 64'd0);
        // Mixed stream: R6, R7, R8, R9, R11, R12 on colliding slots.
        for (int i = 0; i < 4000; i++) begin
            automatic logic [31:0] r = nxt();
            automatic logic [4:0] t = 5'(r[1:0] % 3);
            automatic int s = int'(r[3:2]);
            automatic int v = int'(r[5:4]);
            automatic logic [31:0] b = r[6] ? 32'h40 : 32'h80;
            automatic logic [2:0] sl = r[7] ? 3'd2 : 3'd0;
            apply(r[8], t, s, v, pick_mask(int'(r[12:9] % 6)), b, sl);
        end
        req_valid = 0;
        @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(20 * 150000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule